// File: doc/BRIEF.md
# Privileged Return and Mode Controller

This block executes the four system instructions that change or guard the execution mode of a small core with machine, supervisor and user levels: the supervisor return, the machine return, the wait-for-interrupt and the address-translation fence. The decode stage sends it a one-hot request together with the current privilege level, the status register, the two saved exception PCs and a flag telling whether compressed instructions are supported.

One clock edge after a valid request, the block presents one of two results. The first is a completed action: the rewritten status register and the new privilege level with a redirect to the return PC, a halt request, or a one-cycle TLB-flush pulse. The second is an exception with its code, and in that case the status register and the privilege level pass through unchanged. Each return instruction applies its checks in a fixed order: privilege, then return-PC alignment, then the supervisor-return trap bit. Only when all checks pass does it restore the interrupt-enable bit and reset the previous-privilege field to user.

When no request is made, the registered status and privilege outputs follow their inputs and every pulse output stays low. This lets the core take the outputs as its next state on every cycle.

Top module: `priv_return_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `status_out` is 0, `priv_out` is 2'b11 (machine), `ret_pc` is 0, `exc_code` is 0, and `redirect_valid`, `halt_req`, `flush_pulse` and `exc_valid` are low.
- R2: A supervisor return issued at user level (2'b00) gives `exc_valid` with `exc_code` 2 (illegal instruction). Status and privilege are unchanged.
- R3: A machine return issued below machine level gives `exc_valid` with `exc_code` 2. Status and privilege are unchanged.
- R4: If compressed support is off and bits [1:0] of the selected saved PC are nonzero, a return that passed its privilege check gives `exc_code` 0 (misaligned instruction address) and nothing else changes. A failed privilege check takes precedence and gives code 2.
- R5: A supervisor return that passes the privilege and alignment checks but has status bit 22 (trap supervisor return) set gives `exc_code` 2. A misalignment takes precedence over this check.
- R6: A successful supervisor return sets status bit 1 to the old bit 5, sets bit 5 to 1 and clears bit 8. `priv_out` becomes {0, old bit 8}, `ret_pc` takes `sepc_in`, and `redirect_valid` pulses.
- R7: A successful machine return sets status bit 3 to the old bit 7, sets bit 7 to 1 and clears bits 12:11. `priv_out` becomes the old bits 12:11, `ret_pc` takes `mepc_in`, and `redirect_valid` pulses.
- R8: Wait-for-interrupt at supervisor level (2'b01) with status bit 21 set gives `exc_code` 2. At any other level, or with that bit clear, it raises `halt_req` for one cycle.
- R9: The translation fence gives `exc_code` 2 below supervisor level, or at supervisor level with status bit 20 set. Otherwise it raises `flush_pulse` for one cycle.
- R10: Every result appears on the clock edge that samples the request. At most one of `redirect_valid`, `halt_req`, `flush_pulse` and `exc_valid` is high. Without a request, `status_out` and `priv_out` copy the inputs, `ret_pc` holds, and all pulses stay low.
- R11: The bits of `req_kind` select the instruction as follows: [0] supervisor return, [1] machine return, [2] wait-for-interrupt, [3] fence. A request with zero bits or more than one bit set is treated as no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 4 | One-hot instruction select |
| cur_priv | input | 2 | Current privilege level |
| status_in | input | XLEN | Current status register |
| sepc_in | input | PC_W | Saved supervisor exception PC |
| mepc_in | input | PC_W | Saved machine exception PC |
| compressed_en | input | 1 | Compressed instructions supported |
| status_out | output | XLEN | Next status register |
| priv_out | output | 2 | Next privilege level |
| ret_pc | output | PC_W | Return target PC |
| redirect_valid | output | 1 | Return completed, fetch from `ret_pc` |
| halt_req | output | 1 | Halt until interrupt |
| flush_pulse | output | 1 | Flush translation cache |
| exc_valid | output | 1 | Exception raised |
| exc_code | output | 4 | Exception cause code |

## Verification
A wrong check order or a wrong field update shows up on the ports on the very next clock. It appears as a wrong `exc_code`, a status word with a misplaced bit, or a privilege that does not match the old previous-privilege field. The state is reloaded from the inputs on every cycle, so an error cannot hide and surface later. The bench therefore compares all outputs against a behavioural model on every clock. It drives directed cases aimed at each check precedence, then random requests that also include malformed one-hot selects.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int REQ_W = 4;
  localparam int K_SRET  = 0;
  localparam int K_MRET  = 1;
  localparam int K_WFI   = 2;
  localparam int K_FENCE = 3;

  localparam logic [1:0] LVL_USER  = 2'b00;
  localparam logic [1:0] LVL_SUPER = 2'b01;
  localparam logic [1:0] LVL_MACH  = 2'b11;

  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_SPIE = 5;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_MPP_LO = 11;
  localparam int B_MPP_HI = 12;
  localparam int B_TVM  = 20;
  localparam int B_TW   = 21;
  localparam int B_TSR  = 22;

  localparam int EXC_W = 4;
  localparam logic [EXC_W-1:0] EXC_ILLEGAL  = 4'd2;
  localparam logic [EXC_W-1:0] EXC_MISALIGN = 4'd0;
endpackage

// File: rtl/prc_return_unit.sv
module prc_return_unit
  import prc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int PC_W    = 32,
  parameter bit MACHINE = 1'b0
) (
  input  logic [1:0]       cur_priv,
  input  logic [XLEN-1:0]  status_in,
  input  logic [PC_W-1:0]  epc,
  input  logic             compressed_en,
  output logic             fail,
  output logic [EXC_W-1:0] fail_code,
  output logic [XLEN-1:0]  new_status,
  output logic [1:0]       new_priv
);
  localparam int         IE_BIT   = MACHINE ? B_MIE : B_SIE;
  localparam int         PIE_BIT  = MACHINE ? B_MPIE : B_SPIE;
  localparam logic [1:0] MIN_LVL  = MACHINE ? LVL_MACH : LVL_SUPER;

  logic             pc_odd;
  logic             trap_bit;
  logic [XLEN-1:0]  pp_cleared;

  assign pc_odd = !compressed_en && (epc[1:0] != 2'b00);

  generate
    if (MACHINE) begin : g_mach
      assign trap_bit = 1'b0;
      assign new_priv = status_in[B_MPP_HI:B_MPP_LO];
      always_comb begin
        pp_cleared = status_in;
        pp_cleared[B_MPP_HI:B_MPP_LO] = LVL_USER;
      end
    end else begin : g_super
      assign trap_bit = status_in[B_TSR];
      assign new_priv = {1'b0, status_in[B_SPP]};
      always_comb begin
        pp_cleared = status_in;
        pp_cleared[B_SPP] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    fail      = 1'b0;
    fail_code = EXC_MISALIGN;
    if (cur_priv < MIN_LVL) begin
      fail      = 1'b1;
      fail_code = EXC_ILLEGAL;
    end else if (pc_odd) begin
      fail      = 1'b1;
      fail_code = EXC_MISALIGN;
    end else if (trap_bit) begin
      fail      = 1'b1;
      fail_code = EXC_ILLEGAL;
    end
  end

  always_comb begin
    new_status          = pp_cleared;
    new_status[IE_BIT]  = status_in[PIE_BIT];
    new_status[PIE_BIT] = 1'b1;
  end
endmodule

// File: rtl/prc_sys_unit.sv
module prc_sys_unit
  import prc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      cur_priv,
  input  logic [XLEN-1:0] status_in,
  output logic            wfi_fail,
  output logic            fence_fail
);
  logic at_super;
  assign at_super   = (cur_priv == LVL_SUPER);
  assign wfi_fail   = at_super && status_in[B_TW];
  assign fence_fail = (cur_priv < LVL_SUPER) || (at_super && status_in[B_TVM]);
endmodule

// File: rtl/priv_return_ctrl.sv
module priv_return_ctrl
  import prc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [3:0]       req_kind,
  input  logic [1:0]       cur_priv,
  input  logic [XLEN-1:0]  status_in,
  input  logic [PC_W-1:0]  sepc_in,
  input  logic [PC_W-1:0]  mepc_in,
  input  logic             compressed_en,
  output logic [XLEN-1:0]  status_out,
  output logic [1:0]       priv_out,
  output logic [PC_W-1:0]  ret_pc,
  output logic             redirect_valid,
  output logic             halt_req,
  output logic             flush_pulse,
  output logic             exc_valid,
  output logic [3:0]       exc_code
);
  logic             req_ok;
  logic             s_fail, m_fail, wfi_fail, fence_fail;
  logic [EXC_W-1:0] s_code, m_code;
  logic [XLEN-1:0]  s_status, m_status;
  logic [1:0]       s_priv, m_priv;

  assign req_ok = req_valid && $onehot(req_kind);

  prc_return_unit #(.XLEN(XLEN), .PC_W(PC_W), .MACHINE(1'b0)) u_sret (
    .cur_priv(cur_priv), .status_in(status_in), .epc(sepc_in),
    .compressed_en(compressed_en), .fail(s_fail), .fail_code(s_code),
    .new_status(s_status), .new_priv(s_priv)
  );

  prc_return_unit #(.XLEN(XLEN), .PC_W(PC_W), .MACHINE(1'b1)) u_mret (
    .cur_priv(cur_priv), .status_in(status_in), .epc(mepc_in),
    .compressed_en(compressed_en), .fail(m_fail), .fail_code(m_code),
    .new_status(m_status), .new_priv(m_priv)
  );

  prc_sys_unit #(.XLEN(XLEN)) u_sys (
    .cur_priv(cur_priv), .status_in(status_in),
    .wfi_fail(wfi_fail), .fence_fail(fence_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_out     <= '0;
      priv_out       <= LVL_MACH;
      ret_pc         <= '0;
      redirect_valid <= 1'b0;
      halt_req       <= 1'b0;
      flush_pulse    <= 1'b0;
      exc_valid      <= 1'b0;
      exc_code       <= '0;
    end else begin
      status_out     <= status_in;
      priv_out       <= cur_priv;
      redirect_valid <= 1'b0;
      halt_req       <= 1'b0;
      flush_pulse    <= 1'b0;
      exc_valid      <= 1'b0;
      exc_code       <= '0;
      if (req_ok) begin
        if (req_kind[K_SRET]) begin
          if (s_fail) begin
            exc_valid <= 1'b1;
            exc_code  <= s_code;
          end else begin
            status_out     <= s_status;
            priv_out       <= s_priv;
            ret_pc         <= sepc_in;
            redirect_valid <= 1'b1;
          end
        end else if (req_kind[K_MRET]) begin
          if (m_fail) begin
            exc_valid <= 1'b1;
            exc_code  <= m_code;
          end else begin
            status_out     <= m_status;
            priv_out       <= m_priv;
            ret_pc         <= mepc_in;
            redirect_valid <= 1'b1;
          end
        end else if (req_kind[K_WFI]) begin
          if (wfi_fail) begin
            exc_valid <= 1'b1;
            exc_code  <= EXC_ILLEGAL;
          end else begin
            halt_req <= 1'b1;
          end
        end else begin
          if (fence_fail) begin
            exc_valid <= 1'b1;
            exc_code  <= EXC_ILLEGAL;
          end else begin
            flush_pulse <= 1'b1;
          end
        end
      end
    end
  end

  // R10: at most one result kind per cycle
  a_r10_one_result: assert property (@(posedge clk) disable iff (rst)
    $onehot0({redirect_valid, halt_req, flush_pulse, exc_valid}));

  // R10: no request means no pulse and a held return PC
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !redirect_valid && !halt_req && !flush_pulse && !exc_valid
                   && $stable(ret_pc));

  // R2: supervisor return from user level is illegal
  a_r2_sret_user: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 4'b0001 && cur_priv == 2'b00)
      |=> exc_valid && exc_code == 4'd2 && priv_out == 2'b00);

  // R3: machine return below machine level is illegal
  a_r3_mret_low: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 4'b0010 && cur_priv != 2'b11)
      |=> exc_valid && exc_code == 4'd2);

  // R9: fence from user level is illegal
  a_r9_fence_user: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 4'b1000 && cur_priv == 2'b00)
      |=> exc_valid && !flush_pulse);

  // R7: a machine-return redirect targets the saved machine PC
  a_r7_mret_target: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 4'b0010 && cur_priv == 2'b11 && compressed_en)
      |=> redirect_valid && ret_pc == $past(mepc_in));
endmodule

// File: tb/priv_return_ctrl_bench.sv
module priv_return_ctrl_bench;
  localparam int XLEN = 32;
  localparam int PC_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [3:0]       req_kind = '0;
  logic [1:0]       cur_priv = '0;
  logic [XLEN-1:0]  status_in = '0;
  logic [PC_W-1:0]  sepc_in = '0;
  logic [PC_W-1:0]  mepc_in = '0;
  logic             compressed_en = 1'b0;
  logic [XLEN-1:0]  status_out;
  logic [1:0]       priv_out;
  logic [PC_W-1:0]  ret_pc;
  logic             redirect_valid, halt_req, flush_pulse, exc_valid;
  logic [3:0]       exc_code;

  always #10 clk = ~clk;

  priv_return_ctrl #(.XLEN(XLEN), .PC_W(PC_W)) u_priv_return_ctrl (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // model expectations
  logic [XLEN-1:0] e_status;
  logic [1:0]      e_priv;
  logic [PC_W-1:0] e_pc = '0;
  logic            e_redir, e_halt, e_flush, e_exc;
  logic [3:0]      e_code;
  string           e_tag;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_tag, "status", 64'(status_out), 64'(e_status));
    chk(e_tag, "priv", 64'(priv_out), 64'(e_priv));
    chk(e_tag, "ret_pc", 64'(ret_pc), 64'(e_pc));
    chk(e_tag, "redirect", 64'(redirect_valid), 64'(e_redir));
    chk(e_tag, "halt", 64'(halt_req), 64'(e_halt));
    chk(e_tag, "flush", 64'(flush_pulse), 64'(e_flush));
    chk(e_tag, "exc_valid", 64'(exc_valid), 64'(e_exc));
    chk(e_tag, "exc_code", 64'(exc_code), 64'(e_code));
  endtask

  task automatic raise(input string tag, input int code);
    e_exc = 1; e_code = 4'(code); e_tag = tag;
  endtask

  // behavioural reference, from the requirement text
  task automatic model();
    int lvl, n;
    bit odd;
    e_status = status_in; e_priv = cur_priv;
    e_redir = 0; e_halt = 0; e_flush = 0; e_exc = 0; e_code = 0;
    lvl = int'(cur_priv);
    n = 0;
    for (int i = 0; i < 4; i++) if (req_kind[i]) n++;
    if (!req_valid) begin e_tag = "R10"; return; end
    if (n != 1) begin e_tag = "R11"; return; end
    if (req_kind == 4'b0001) begin
      odd = !compressed_en && (sepc_in % 4 != 0);
      if (lvl < 1) raise("R2", 2);
      else if (odd) raise("R4", 0);
      else if (status_in[22]) raise("R5", 2);
      else begin
        e_tag = "R6";
        e_status[1] = status_in[5];
        e_status[5] = 1'b1;
        e_status[8] = 1'b0;
        e_priv = status_in[8] ? 2'd1 : 2'd0;
        e_pc = sepc_in; e_redir = 1;
      end
    end else if (req_kind == 4'b0010) begin
      odd = !compressed_en && (mepc_in % 4 != 0);
      if (lvl != 3) raise("R3", 2);
      else if (odd) raise("R4", 0);
      else begin
        e_tag = "R7";
        e_status[3] = status_in[7];
        e_status[7] = 1'b1;
        e_status[11] = 1'b0;
        e_status[12] = 1'b0;
        e_priv = {status_in[12], status_in[11]};
        e_pc = mepc_in; e_redir = 1;
      end
    end else if (req_kind == 4'b0100) begin
      if (lvl == 1 && status_in[21]) raise("R8", 2);
      else begin e_tag = "R8"; e_halt = 1; end
    end else begin
      if (lvl == 0 || (lvl == 1 && status_in[20])) raise("R9", 2);
      else begin e_tag = "R9"; e_flush = 1; end
    end
  endtask

  task automatic step(input logic v, input logic [3:0] k, input logic [1:0] p,
                      input logic [31:0] st, input logic [31:0] se,
                      input logic [31:0] me, input logic c);
    req_valid = v; req_kind = k; cur_priv = p; status_in = st;
    sepc_in = se; mepc_in = me; compressed_en = c;
    rst = 1'b0;
    model();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "status", 64'(status_out), 64'h0);
    chk("R1", "priv", 64'(priv_out), 64'h3);
    chk("R1", "ret_pc", 64'(ret_pc), 64'h0);
    chk("R1", "pulses", 64'({redirect_valid, halt_req, flush_pulse, exc_valid}), 64'h0);
    chk("R1", "exc_code", 64'(exc_code), 64'h0);

    // R2
    step(1, 4'b0001, 2'b00, 32'h0000_0120, 32'h100, 32'h200, 0);
    // R3
    step(1, 4'b0010, 2'b01, 32'h0000_1880, 32'h100, 32'h200, 0);
    step(1, 4'b0010, 2'b10, 32'h0000_1880, 32'h100, 32'h200, 1);
    // R4 misaligned, and privilege precedence
    step(1, 4'b0001, 2'b01, 32'h0000_0020, 32'h102, 32'h200, 0);
    step(1, 4'b0010, 2'b11, 32'h0000_0080, 32'h100, 32'h201, 0);
    step(1, 4'b0001, 2'b00, 32'h0000_0020, 32'h103, 32'h200, 0);
    // R5 trap bit, and misalignment precedence
    step(1, 4'b0001, 2'b11, 32'h0040_0020, 32'h104, 32'h200, 0);
    step(1, 4'b0001, 2'b01, 32'h0040_0020, 32'h106, 32'h200, 0);
    // R6 successful supervisor returns
    step(1, 4'b0001, 2'b01, 32'h0000_0120, 32'h302, 32'h200, 1);
    step(1, 4'b0001, 2'b11, 32'h0000_0002, 32'h400, 32'h200, 0);
    // R7 successful machine returns
    step(1, 4'b0010, 2'b11, 32'h0000_0880, 32'h100, 32'h500, 0);
    step(1, 4'b0010, 2'b11, 32'h0000_1808, 32'h100, 32'h602, 1);
    // R10 idle keeps ret_pc, follows inputs
    step(0, 4'b0001, 2'b01, 32'hdead_beef, 32'h700, 32'h800, 0);
    // R8
    step(1, 4'b0100, 2'b01, 32'h0020_0000, 32'h0, 32'h0, 0);
    step(1, 4'b0100, 2'b11, 32'h0020_0000, 32'h0, 32'h0, 0);
    step(1, 4'b0100, 2'b00, 32'h0020_0000, 32'h0, 32'h0, 0);
    step(1, 4'b0100, 2'b01, 32'h0000_0000, 32'h0, 32'h0, 0);
    // R9
    step(1, 4'b1000, 2'b00, 32'h0, 32'h0, 32'h0, 0);
    step(1, 4'b1000, 2'b01, 32'h0010_0000, 32'h0, 32'h0, 0);
    step(1, 4'b1000, 2'b01, 32'h0, 32'h0, 32'h0, 0);
    step(1, 4'b1000, 2'b11, 32'h0010_0000, 32'h0, 32'h0, 0);
    // R11 malformed selects
    step(1, 4'b0011, 2'b11, 32'h0000_1888, 32'h900, 32'ha00, 1);
    step(1, 4'b0000, 2'b11, 32'h0000_1888, 32'h900, 32'ha00, 1);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] k;
      int sel;
      sel = int'($urandom % 7);
      k = (sel < 4) ? 4'(1 << sel) : (sel == 4 ? 4'b0000 : 4'b0101);
      step(($urandom % 8) != 0, k, 2'($urandom), $urandom, $urandom,
           $urandom, 1'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule